// File: doc/BRIEF.md
# Shadow Stack Token Release Unit

This unit executes a privileged operation that marks a supervisor shadow stack token as no longer in use. A decoded request arrives with a one-cycle `start` pulse. The request carries:

- the operand linear address;
- the processor mode and current privilege level;
- the two feature-enable bits;
- a lock-prefix indication;
- two pre-computed segmentation fault flags;
- the current status flags and shadow stack pointer.

The unit first checks for faults in a fixed priority. If none is found, it performs a locked 8-byte compare-and-exchange on the token through a simple request/acknowledge memory port. The value it expects is the operand address with bit 0, the busy bit, set. The value it stores is the address with bit 0 clear.

A failed compare is not a fault. It sets the carry flag and leaves memory untouched. Any completion without a fault clears the other arithmetic flags and returns a pointer of zero. A fault returns the incoming flags and pointer unchanged, together with a fault code. Results are valid during a single-cycle `done` pulse.

Top module: `sstk_release_unit`

## Requirements
- R1: The fault code is invalid-opcode (1) when the mode is real-address (0) or virtual-8086 (1), when the lock prefix is set, or when either enable bit is 0.
- R2: The fault code is general-protection (2) when the privilege level is non-zero and no invalid-opcode condition exists.
- R3: The fault code is general-protection (2) when any of the following holds: the address has a non-zero value in bits [2:0]; the mode is 64-bit (3) and bits [63:47] are not all equal; the segment-GP input is set. Otherwise, if the segment-stack input is set, the code is stack-fault (3).
- R4: Only the highest-priority fault is reported. The order is: unrecognised mode, lock prefix or enables, privilege, alignment or canonical form, segment-GP, segment-stack, page fault. The code 0 means no fault.
- R5: Every memory request targets the operand address and is issued with the lock held. The read comes first. The lock stays asserted without a gap into the write.
- R6: When the token read equals address|1, the unit writes address with bit 0 cleared and reports the carry flag as 0.
- R7: When the token read differs from address|1, no write is issued, the carry flag is 1, and the lock is released by the time `done` is asserted.
- R8: On completion without a fault, the pointer output is 0. Flag bits 1 to 5 (parity, aux-carry, zero, sign, overflow) are 0. Bit 0 is the carry flag.
- R9: A page fault on the read or the write acknowledge gives fault code 4. A page fault on the read issues no write.
- R10: On any fault other than a page fault, no memory request is issued. On any fault, `flags_out` and `ptr_out` equal the inputs captured with `start`.
- R11: `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe, accepted when idle |
| req_addr | input | 64 | Operand linear address |
| req_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| req_lock | input | 1 | Lock prefix present |
| cfe_en | input | 1 | Control-flow enforcement enable |
| sstk_en | input | 1 | Supervisor shadow stack enable |
| req_cpl | input | 2 | Current privilege level |
| seg_gp_flt | input | 1 | Segment check produced a general-protection condition |
| seg_ss_flt | input | 1 | Segment check produced a stack-segment condition |
| flags_in | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |
| ptr_in | input | 64 | Current shadow stack pointer |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_lock | output | 1 | Bus lock for the read-modify-write |
| mem_addr | output | 64 | Request address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 64 | Read data, valid with acknowledge |
| mem_pf | input | 1 | Page fault, valid with acknowledge |
| done | output | 1 | Results valid |
| fault | output | 3 | Fault code |
| flags_out | output | 6 | Resulting flags |
| ptr_out | output | 64 | Resulting shadow stack pointer |

## Verification
The stimulus goes after overlapping fault conditions. One example is a locked request at non-zero privilege on a misaligned address, where an encoder with a swapped priority reports general-protection instead of invalid-opcode. Tokens are chosen to differ from the expected value only in the busy bit or in one address bit. A comparator that masks bits, or a store issued regardless of the compare, therefore shows up as a corrupted token or a wrong carry flag. Page faults are injected separately on the read and on the write acknowledge. This catches a design that writes after a faulting read, or that zeroes the pointer on a fault. Memory latency varies between 0 and 2 cycles, which exposes a lock dropped between the read and the write.

// File: rtl/sstk_pkg.sv
package sstk_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_GP   = 3'd2,
    FLT_SS   = 3'd3,
    FLT_PF   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    MD_REAL = 2'd0,
    MD_V86  = 2'd1,
    MD_PROT = 2'd2,
    MD_LONG = 2'd3
  } mode_e;

  localparam int FLG_W  = 6;
  localparam int FLG_CF = 0;

  // flags after a completion without a fault: only carry may be set
  function automatic logic [FLG_W-1:0] done_flags(input logic invalid);
    logic [FLG_W-1:0] f;
    f = '0;
    f[FLG_CF] = invalid;
    return f;
  endfunction
endpackage

// File: rtl/sstk_fault_check.sv
module sstk_fault_check
  import sstk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48,
  parameter int CPL_W   = 2,
  parameter int ALIGN_B = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode,
  input  logic              lock_pfx,
  input  logic              cfe_en,
  input  logic              sstk_en,
  input  logic [CPL_W-1:0]  cpl,
  input  logic              seg_gp,
  input  logic              seg_ss,
  output fault_e            fault_code
);
  localparam int TOP_W = ADDR_W - VA_BITS + 1;

  function automatic logic is_canon(input logic [ADDR_W-1:0] a);
    logic [TOP_W-1:0] upper;
    upper = a[ADDR_W-1:VA_BITS-1];
    return (&upper) || (~|upper);
  endfunction

  function automatic logic is_misaligned(input logic [ADDR_W-1:0] a);
    return |a[ALIGN_B-1:0];
  endfunction

  logic mode_bad, ud_cond, priv_bad, addr_bad;

  always_comb begin
    mode_bad = (mode == MD_REAL) || (mode == MD_V86);
    ud_cond  = lock_pfx || !cfe_en || !sstk_en;
    priv_bad = (cpl != '0);
    addr_bad = is_misaligned(addr) || ((mode == MD_LONG) && !is_canon(addr));
  end

  always_comb begin
    if (mode_bad)      fault_code = FLT_UD;
    else if (ud_cond)  fault_code = FLT_UD;
    else if (priv_bad) fault_code = FLT_GP;
    else if (addr_bad) fault_code = FLT_GP;
    else if (seg_gp)   fault_code = FLT_GP;
    else if (seg_ss)   fault_code = FLT_SS;
    else               fault_code = FLT_NONE;
  end

  // R1
  lock_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    check_en && lock_pfx |-> fault_code == FLT_UD);

  // R2
  priv_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    check_en && !lock_pfx && cfe_en && sstk_en && mode[1] && cpl != '0
      |-> fault_code == FLT_GP);

  // R4
  ss_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    check_en && fault_code == FLT_SS |-> seg_ss && !seg_gp && cpl == '0);
endmodule

// File: rtl/sstk_token_cmp.sv
module sstk_token_cmp #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] exp_tok,
  output logic [ADDR_W-1:0] repl_tok,
  output logic              match
);
  function automatic logic [ADDR_W-1:0] busy_token(input logic [ADDR_W-1:0] a);
    return a | ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] free_token(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(1);
  endfunction

  always_comb begin
    exp_tok  = busy_token(addr);
    repl_tok = free_token(addr);
    match    = (rdata == exp_tok);
  end

  // R6
  busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> rdata[0] && !repl_tok[0] && (rdata[ADDR_W-1:1] == repl_tok[ADDR_W-1:1]));
endmodule

// File: rtl/sstk_release_unit.sv
module sstk_release_unit
  import sstk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48,
  parameter int CPL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_mode,
  input  logic              req_lock,
  input  logic              cfe_en,
  input  logic              sstk_en,
  input  logic [CPL_W-1:0]  req_cpl,
  input  logic              seg_gp_flt,
  input  logic              seg_ss_flt,
  input  logic [5:0]        flags_in,
  input  logic [ADDR_W-1:0] ptr_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_pf,
  output logic              done,
  output logic [2:0]        fault,
  output logic [5:0]        flags_out,
  output logic [ADDR_W-1:0] ptr_out
);
  localparam int S_IDLE = 0;
  localparam int S_CHECK = 1;
  localparam int S_RD = 2;
  localparam int S_WR = 3;
  localparam int S_DONE = 4;
  localparam int ST_N = 5;

  logic [ST_N-1:0]   state;
  logic [ADDR_W-1:0] addr_q, ptr_q, ptr_res;
  logic [1:0]        mode_q;
  logic              lock_q, cfe_q, sse_q, sgp_q, sss_q;
  logic [CPL_W-1:0]  cpl_q;
  logic [FLG_W-1:0]  flg_q, flg_res;
  fault_e            flt_res, chk_fault;

  // internal events, named for the assertions
  logic              chk_stage, rd_done, wr_done, cmp_ok;
  logic [ADDR_W-1:0] exp_tok, repl_tok;

  sstk_fault_check #(
    .ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .CPL_W(CPL_W), .ALIGN_B(3)
  ) u_chk (
    .clk(clk), .rst_n(rst_n), .check_en(chk_stage),
    .addr(addr_q), .mode(mode_q), .lock_pfx(lock_q),
    .cfe_en(cfe_q), .sstk_en(sse_q), .cpl(cpl_q),
    .seg_gp(sgp_q), .seg_ss(sss_q), .fault_code(chk_fault)
  );

  sstk_token_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .addr(addr_q), .rdata(mem_rdata),
    .exp_tok(exp_tok), .repl_tok(repl_tok), .match(cmp_ok)
  );

  always_comb begin
    chk_stage = state[S_CHECK];
    rd_done   = state[S_RD] && mem_ack;
    wr_done   = state[S_WR] && mem_ack;
    mem_req   = state[S_RD] || state[S_WR];
    mem_we    = state[S_WR];
    mem_lock  = state[S_RD] || state[S_WR];
    mem_addr  = addr_q;
    mem_wdata = repl_tok;
    done      = state[S_DONE];
    fault     = flt_res;
    flags_out = flg_res;
    ptr_out   = ptr_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_N'(1) << S_IDLE;
      addr_q  <= '0;
      ptr_q   <= '0;
      mode_q  <= MD_REAL;
      lock_q  <= 1'b0;
      cfe_q   <= 1'b0;
      sse_q   <= 1'b0;
      sgp_q   <= 1'b0;
      sss_q   <= 1'b0;
      cpl_q   <= '0;
      flg_q   <= '0;
      flt_res <= FLT_NONE;
      flg_res <= '0;
      ptr_res <= '0;
    end else begin
      unique case (1'b1)
        state[S_IDLE]: begin
          if (start) begin
            addr_q <= req_addr;
            mode_q <= req_mode;
            lock_q <= req_lock;
            cfe_q  <= cfe_en;
            sse_q  <= sstk_en;
            cpl_q  <= req_cpl;
            sgp_q  <= seg_gp_flt;
            sss_q  <= seg_ss_flt;
            flg_q  <= flags_in;
            ptr_q  <= ptr_in;
            state  <= ST_N'(1) << S_CHECK;
          end
        end
        state[S_CHECK]: begin
          if (chk_fault != FLT_NONE) begin
            flt_res <= chk_fault;
            flg_res <= flg_q;
            ptr_res <= ptr_q;
            state   <= ST_N'(1) << S_DONE;
          end else begin
            state <= ST_N'(1) << S_RD;
          end
        end
        state[S_RD]: begin
          if (rd_done) begin
            if (mem_pf) begin
              flt_res <= FLT_PF;
              flg_res <= flg_q;
              ptr_res <= ptr_q;
              state   <= ST_N'(1) << S_DONE;
            end else if (cmp_ok) begin
              state <= ST_N'(1) << S_WR;
            end else begin
              flt_res <= FLT_NONE;
              flg_res <= done_flags(1'b1);
              ptr_res <= '0;
              state   <= ST_N'(1) << S_DONE;
            end
          end
        end
        state[S_WR]: begin
          if (wr_done) begin
            flt_res <= mem_pf ? FLT_PF : FLT_NONE;
            flg_res <= mem_pf ? flg_q : done_flags(1'b0);
            ptr_res <= mem_pf ? ptr_q : '0;
            state   <= ST_N'(1) << S_DONE;
          end
        end
        state[S_DONE]: state <= ST_N'(1) << S_IDLE;
        default:       state <= ST_N'(1) << S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  // R5
  lock_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_lock) && mem_lock);

  // R6
  wr_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_rdata) == (mem_addr | ADDR_W'(1)) && !$past(mem_pf));

  // R7
  mismatch_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == FLT_NONE && flags_out[FLG_CF] |-> !$past(mem_we) && !mem_lock);

  // R8
  ok_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == FLT_NONE |-> ptr_out == '0 && flags_out[FLG_W-1:1] == '0);

  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stage && chk_fault != FLT_NONE |=> !mem_req);

  // R9
  pf_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && mem_pf |=> !mem_req);
endmodule

// File: tb/sstk_release_unit_test.sv
`timescale 1ns/1ps
module sstk_release_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_mode = '0;
  logic        req_lock = 1'b0, cfe_en = 1'b0, sstk_en = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic        seg_gp_flt = 1'b0, seg_ss_flt = 1'b0;
  logic [5:0]  flags_in = '0;
  logic [63:0] ptr_in = '0;
  logic        mem_req, mem_we, mem_lock, done;
  logic [63:0] mem_addr, mem_wdata, ptr_out;
  logic        mem_ack = 1'b0, mem_pf = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [2:0]  fault;
  logic [5:0]  flags_out;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sstk_release_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
    .req_mode(req_mode), .req_lock(req_lock), .cfe_en(cfe_en), .sstk_en(sstk_en),
    .req_cpl(req_cpl), .seg_gp_flt(seg_gp_flt), .seg_ss_flt(seg_ss_flt),
    .flags_in(flags_in), .ptr_in(ptr_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_pf(mem_pf), .done(done),
    .fault(fault), .flags_out(flags_out), .ptr_out(ptr_out)
  );

  // memory model: one token word, configurable latency and fault injection
  logic [63:0] token = '0, tok_init = '0;
  logic        load_tok = 1'b0, pf_rd = 1'b0, pf_wr = 1'b0;
  int          lat = 0, wcnt = 0, req_total = 0, lock_bad = 0, addr_bad = 0;
  logic [63:0] exp_addr = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_pf  <= 1'b0;
    if (load_tok) token <= tok_init;
    if (mem_req && !mem_ack) begin
      if (wcnt < lat) wcnt <= wcnt + 1;
      else begin
        wcnt      <= 0;
        mem_ack   <= 1'b1;
        mem_rdata <= token;
        req_total <= req_total + 1;
        if (!mem_lock) lock_bad <= lock_bad + 1;
        if (mem_addr != exp_addr) addr_bad <= addr_bad + 1;
        if (mem_we) begin
          mem_pf <= pf_wr;
          if (!pf_wr) token <= mem_wdata;
        end else begin
          mem_pf <= pf_rd;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [2:0] ref_pre(input logic [1:0] md, input logic lk, input logic ce,
      input logic se, input logic [1:0] pl, input logic [63:0] a, input logic g, input logic s);
    logic canon;
    canon = (a[63:47] == 17'h0) || (a[63:47] == 17'h1ffff);
    if (md < 2 || lk || !(ce && se)) return 3'd1;
    if (pl != 0) return 3'd2;
    if (a[2:0] != 0 || (md == 3 && !canon) || g) return 3'd2;
    if (s) return 3'd3;
    return 3'd0;
  endfunction

  task automatic run_op(input logic [1:0] md, input logic lk, input logic ce, input logic se,
      input logic [1:0] pl, input logic [63:0] a, input logic g, input logic s,
      input logic pr, input logic pw, input logic [63:0] tk, input int l);
    logic [2:0] pre, ef;
    logic [5:0] fi, ef_fl;
    logic [63:0] pi, ep, et;
    logic match;
    int r0, er, n;
    string tag;
    fi = 6'($urandom);
    pi = {$urandom, $urandom};
    pre = ref_pre(md, lk, ce, se, pl, a, g, s);
    match = (tk == (a | 64'd1));
    et = tk;
    if (pre != 0)      begin ef = pre; er = 0; end
    else if (pr)       begin ef = 3'd4; er = 1; end
    else if (!match)   begin ef = 3'd0; er = 1; end
    else if (pw)       begin ef = 3'd4; er = 2; end
    else               begin ef = 3'd0; er = 2; et = {a[63:1], 1'b0}; end
    ef_fl = (ef != 0) ? fi : ((pre == 0 && !pr && !match) ? 6'd1 : 6'd0);
    ep = (ef != 0) ? pi : 64'd0;
    case (ef)
      3'd1: tag = "R1";
      3'd2: tag = (pl != 0 && pre == 2 && md >= 2 && !lk && ce && se) ? "R2" : "R3";
      3'd3: tag = "R3";
      3'd4: tag = "R9";
      default: tag = "R4";
    endcase
    @(negedge clk);
    tok_init = tk; load_tok = 1'b1; lat = l; pf_rd = pr; pf_wr = pw; exp_addr = a;
    @(negedge clk);
    load_tok = 1'b0;
    r0 = req_total;
    req_mode = md; req_lock = lk; cfe_en = ce; sstk_en = se; req_cpl = pl;
    req_addr = a; seg_gp_flt = g; seg_ss_flt = s; flags_in = fi; ptr_in = pi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    req_addr = ~a; flags_in = ~fi; ptr_in = ~pi;   // capture must hold the start-cycle values
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 done missing: actual=0 expected=1");
      return;
    end
    chk(tag, 64'(fault), 64'(ef), "fault code");
    chk("R8", 64'(flags_out), 64'(ef_fl), "flags");
    chk((ef != 0) ? "R10" : "R8", ptr_out, ep, "pointer");
    chk("R7", 64'(mem_lock), 64'd0, "lock released at done");
    @(negedge clk);
    chk("R11", 64'(done), 64'd0, "done pulse width");
    chk(er == 2 ? "R6" : "R7", token, et, "token after op");
    chk(ef == 4 ? "R9" : "R10", 64'(req_total - r0), 64'(er), "memory requests");
  endtask

  function automatic logic [63:0] rand_addr();
    logic [63:0] a;
    a = {$urandom, $urandom};
    if ($urandom_range(0, 9) < 8) a[63:47] = {17{a[47]}};
    if ($urandom_range(0, 9) < 8) a[2:0] = 3'b000;
    return a;
  endfunction

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] a;
    logic [63:0] tk;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // reset state
    chk("R11", 64'(done), 64'd0, "reset done");
    chk("R5", 64'(mem_req), 64'd0, "reset mem_req");
    chk("R5", 64'(mem_lock), 64'd0, "reset mem_lock");
    rst_n = 1'b1;
    a = 64'h0000_7fff_1234_5670;
    // R6 token busy, good path with each latency
    for (int l = 0; l < 3; l++) run_op(2'd3, 0, 1, 1, 0, a, 0, 0, 0, 0, a | 64'd1, l);
    // R7 token not busy / one address bit off
    run_op(2'd3, 0, 1, 1, 0, a, 0, 0, 0, 0, a, 1);
    run_op(2'd2, 0, 1, 1, 0, a, 0, 0, 0, 0, (a | 64'd1) ^ 64'h100, 0);
    // R1 each invalid-opcode source
    run_op(2'd0, 0, 1, 1, 0, a, 0, 0, 0, 0, a | 64'd1, 0);
    run_op(2'd1, 0, 1, 1, 0, a, 0, 0, 0, 0, a | 64'd1, 0);
    run_op(2'd3, 1, 1, 1, 0, a, 0, 0, 0, 0, a | 64'd1, 0);
    run_op(2'd3, 0, 0, 1, 0, a, 0, 0, 0, 0, a | 64'd1, 0);
    run_op(2'd3, 0, 1, 0, 0, a, 0, 0, 0, 0, a | 64'd1, 0);
    // R2 privilege; R4 lock beats privilege and misalignment
    run_op(2'd3, 0, 1, 1, 3, a, 0, 0, 0, 0, a | 64'd1, 0);
    run_op(2'd3, 1, 1, 1, 3, a | 64'd4, 1, 1, 0, 0, a | 64'd1, 0);
    // R3 alignment, canonical, segment flags
    run_op(2'd3, 0, 1, 1, 0, a | 64'd2, 0, 0, 0, 0, a | 64'd1, 0);
    run_op(2'd3, 0, 1, 1, 0, a ^ 64'h8000_0000_0000_0000, 0, 0, 0, 0, a | 64'd1, 0);
    run_op(2'd2, 0, 1, 1, 0, a ^ 64'h8000_0000_0000_0000, 0, 0, 0, 0,
           (a ^ 64'h8000_0000_0000_0000) | 64'd1, 0);
    run_op(2'd3, 0, 1, 1, 0, a, 1, 1, 0, 0, a | 64'd1, 0);
    run_op(2'd3, 0, 1, 1, 0, a, 0, 1, 0, 0, a | 64'd1, 2);
    // R9 page fault on read and on write
    run_op(2'd3, 0, 1, 1, 0, a, 0, 0, 1, 0, a | 64'd1, 1);
    run_op(2'd3, 0, 1, 1, 0, a, 0, 0, 0, 1, a | 64'd1, 2);
    // random mix
    for (int i = 0; i < 400; i++) begin
      a = rand_addr();
      case ($urandom_range(0, 3))
        0, 1: tk = a | 64'd1;
        2:    tk = a & ~64'd1;
        default: tk = (a | 64'd1) ^ (64'd1 << $urandom_range(1, 63));
      endcase
      run_op(2'($urandom_range(0, 9) < 2 ? $urandom_range(0, 1) : $urandom_range(2, 3)),
             $urandom_range(0, 9) == 0, $urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
             2'($urandom_range(0, 9) < 8 ? 0 : $urandom_range(1, 3)), a,
             $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
             $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0, tk, $urandom_range(0, 2));
    end
    chk("R5", 64'(lock_bad), 64'd0, "requests without lock");
    chk("R5", 64'(addr_bad), 64'd0, "requests to wrong address");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule